// File: doc/BRIEF.md
# Pending Interrupt Priority Masking Selector

This block picks the single interrupt that a core may take right now. Its inputs are a vector of level pending requests, the machine-state bits that gate them (external enable, hypervisor state, problem state), a resume-as-reset flag, and the partition-control enables. When the core is running, the requests pass through per-source enable gates and then a fixed priority chain. When the core is halted, that chain is bypassed. A separate per-source wake mask then decides which pending request may wake the core.

The choice is registered and presented as a valid flag plus a 4-bit source code. A consumer acknowledges a delivery by raising `out_ready` while `out_valid` is high. The result follows the pending levels, so `out_valid` can drop without an acknowledge when a request goes away. Holding `out_ready` low stalls nothing, because the block keeps no queue. It simply keeps reporting the current best source. An accepted acknowledge of a source that clears on delivery produces a one-cycle clear pulse back towards the pending register.

Top module: `ips_sel`

## Requirements
- R1: Source index i is reported as code i+1. Bit 0 is machine check, bit 1 is hypervisor decrementer, bit 2 is external and bit 3 is decrementer. Bits 4 and 5 are auxiliary sources that need the external enable. When nothing is deliverable, out_valid is 0 and out_code is 0.
- R2: When halted is 1, the selected source is the lowest-index pending source whose wake_en bit is set, and all other gating is ignored. For example, external (bit 2) wakes the core only when wake_en[2] is 1.
- R3: When not halted, a pending machine check (bit 0) is always selected, whatever the enables are.
- R4: When not halted, the hypervisor decrementer (bit 1) is deliverable only if hdec_en is 1 and either the effective enable is 1 or hv is 0.
- R5: When not halted, external (bit 2) is deliverable if either of two conditions holds. The first is that the effective enable is 1 and the combination hv_ext_block=1, hv=1, pr=0 is not present. The second is that hv_capable is 1, hv is 0 and ext_guest_off is 0.
- R6: The effective enable is ee OR resume_rst. When not halted, sources 3, 4 and 5 are deliverable only when the effective enable is 1.
- R7: Among the deliverable sources, the lowest index wins.
- R8: clr_pend has bit 1 high for exactly the cycle in which out_valid, out_ready and out_code=2 are all high. In every other case clr_pend is 0.
- R9: Bits 6 and 7 are unused sources. It is illegal for them to be pending, and they are never reported, so codes 7 and 8 never appear.
- R10: The output is registered. It reflects the inputs sampled at the previous rising clock edge, and it is valid=0, code=0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | 8 | Pending request levels, one per source |
| wake_en | input | 8 | Per-source wake mask used while halted |
| ee | input | 1 | Machine-state external enable |
| hv | input | 1 | Core is in hypervisor state |
| pr | input | 1 | Core is in problem state |
| resume_rst | input | 1 | Resume-as-reset flag, forces the effective enable |
| halted | input | 1 | Core is in the low-power halted state |
| hv_capable | input | 1 | Hypervisor mode is supported |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| hv_ext_block | input | 1 | Blocks external delivery to the hypervisor |
| ext_guest_off | input | 1 | When 0, external is delivered to a guest regardless of ee |
| out_valid | output | 1 | A source is deliverable |
| out_code | output | 4 | Selected source code (index+1), 0 when none |
| out_ready | input | 1 | Acknowledge of the reported source |
| clr_pend | output | 8 | One-cycle clear pulse for sources cleared on delivery |

## Verification
On every cycle, the assertions check four things: that no unused source is pending, that machine check always wins outside halt, that a selected decrementer or hypervisor decrementer had its enables, and that clear pulses occur only on an accepted acknowledge. Only the bench's sweep can show that the full decision matches the rules for every combination. That decision depends jointly on the state bits and the partition enables. The sweep also covers the exact wake choice in halt, the lowest-index ordering, and the one-cycle latency.

// File: rtl/ips_pkg.sv
package ips_pkg;
  localparam int unsigned IPS_NSRC = 8;
  localparam int unsigned SRC_MCK  = 0;
  localparam int unsigned SRC_HDEC = 1;
  localparam int unsigned SRC_EXT  = 2;
  localparam int unsigned SRC_DEC  = 3;
  localparam logic [IPS_NSRC-1:0] IPS_UNUSED   = 8'hC0;
  localparam logic [IPS_NSRC-1:0] IPS_CLR_ACK  = 8'h02;

  typedef struct packed {
    logic ee;
    logic hv;
    logic pr;
    logic resume_rst;
    logic hv_capable;
    logic hdec_en;
    logic hv_ext_block;
    logic ext_guest_off;
  } ips_ctl_t;
endpackage

// File: rtl/ips_gate.sv
module ips_gate
  import ips_pkg::*;
#(
  parameter int unsigned NSRC = IPS_NSRC,
  parameter logic [NSRC-1:0] UNUSED_MASK = IPS_UNUSED
) (
  input  ips_ctl_t        ctl,
  output logic [NSRC-1:0] allow
);
  logic ee_eff;
  logic ext_host;
  logic ext_guest;

  assign ee_eff    = ctl.ee | ctl.resume_rst;
  assign ext_host  = ee_eff & ~(ctl.hv_ext_block & ctl.hv & ~ctl.pr);
  assign ext_guest = ctl.hv_capable & ~ctl.hv & ~ctl.ext_guest_off;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_allow
      if (i == SRC_MCK) begin : g_mck
        assign allow[i] = ~UNUSED_MASK[i];
      end else if (i == SRC_HDEC) begin : g_hdec
        assign allow[i] = ~UNUSED_MASK[i] & ctl.hdec_en & (ee_eff | ~ctl.hv);
      end else if (i == SRC_EXT) begin : g_ext
        assign allow[i] = ~UNUSED_MASK[i] & (ext_host | ext_guest);
      end else begin : g_ee
        assign allow[i] = ~UNUSED_MASK[i] & ee_eff;
      end
    end
  endgenerate
endmodule

// File: rtl/ips_prio.sv
module ips_prio #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned CW   = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0] req,
  output logic            valid,
  output logic [CW-1:0]   code
);
  always_comb begin
    valid = 1'b0;
    code  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        code  = CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/ips_sel.sv
module ips_sel
  import ips_pkg::*;
#(
  parameter int unsigned NSRC = IPS_NSRC,
  parameter logic [NSRC-1:0] UNUSED_MASK = IPS_UNUSED,
  parameter logic [NSRC-1:0] CLR_MASK    = IPS_CLR_ACK,
  localparam int unsigned CW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] wake_en,
  input  logic            ee,
  input  logic            hv,
  input  logic            pr,
  input  logic            resume_rst,
  input  logic            halted,
  input  logic            hv_capable,
  input  logic            hdec_en,
  input  logic            hv_ext_block,
  input  logic            ext_guest_off,
  output logic            out_valid,
  output logic [CW-1:0]   out_code,
  input  logic            out_ready,
  output logic [NSRC-1:0] clr_pend
);
  ips_ctl_t        ctl;
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] elig;
  logic            sel_valid;
  logic [CW-1:0]   sel_code;

  assign ctl = '{ee: ee, hv: hv, pr: pr, resume_rst: resume_rst,
                 hv_capable: hv_capable, hdec_en: hdec_en,
                 hv_ext_block: hv_ext_block, ext_guest_off: ext_guest_off};

  ips_gate #(.NSRC(NSRC), .UNUSED_MASK(UNUSED_MASK)) u_gate (
    .ctl   (ctl),
    .allow (allow)
  );

  assign elig = halted ? (pend & wake_en & ~UNUSED_MASK)
                       : (pend & allow);

  ips_prio #(.NSRC(NSRC), .CW(CW)) u_prio (
    .req   (elig),
    .valid (sel_valid),
    .code  (sel_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= sel_valid;
      out_code  <= sel_code;
    end
  end

  always_comb begin
    clr_pend = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (out_valid && out_ready && out_code == CW'(i + 1) && CLR_MASK[i])
        clr_pend[i] = 1'b1;
    end
  end

  AST_NO_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & UNUSED_MASK) == '0); // R9
  AST_MCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && pend[SRC_MCK]) |-> (sel_valid && sel_code == CW'(SRC_MCK + 1))); // R3
  AST_HDEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && sel_code == CW'(SRC_HDEC + 1)) |-> (hdec_en && (ee || resume_rst || !hv))); // R4
  AST_DEC_NEEDS_EE: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && sel_code == CW'(SRC_DEC + 1)) |-> (ee || resume_rst)); // R6
  AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && sel_valid) |-> ((pend & wake_en) != '0)); // R2
  AST_CLR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend != '0) |-> (out_valid && out_ready && $onehot0(clr_pend))); // R8
endmodule

// File: tb/ips_sel_test.sv
module ips_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend = '0, wake_en = '0;
  logic       ee = 0, hv = 0, pr = 0, resume_rst = 0, halted = 0;
  logic       hv_capable = 0, hdec_en = 0, hv_ext_block = 0, ext_guest_off = 0;
  logic       out_valid, out_ready = 0;
  logic [3:0] out_code;
  logic [7:0] clr_pend;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ips_sel uut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .wake_en(wake_en), .ee(ee),
    .hv(hv), .pr(pr), .resume_rst(resume_rst), .halted(halted),
    .hv_capable(hv_capable), .hdec_en(hdec_en), .hv_ext_block(hv_ext_block),
    .ext_guest_off(ext_guest_off), .out_valid(out_valid), .out_code(out_code),
    .out_ready(out_ready), .clr_pend(clr_pend)
  );

  function automatic logic [4:0] ref_sel();
    logic eff;
    logic [5:0] ok;
    eff   = ee | resume_rst;
    ok[0] = 1'b1;
    ok[1] = hdec_en & (eff | ~hv);
    ok[2] = (eff & ~(hv_ext_block & hv & ~pr)) | (hv_capable & ~hv & ~ext_guest_off);
    ok[3] = eff; ok[4] = eff; ok[5] = eff;
    for (int i = 0; i < 6; i++) begin
      if (pend[i] && (halted ? wake_en[i] : ok[i])) return {1'b1, 4'(i + 1)};
    end
    return 5'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_check(input string tag);
    logic [4:0] exp;
    exp = ref_sel();
    @(negedge clk);
    check(tag, {27'd0, out_valid, out_code}, {27'd0, exp});
    if (out_code == 4'd7 || out_code == 4'd8) check("R9 unused code", {28'd0, out_code}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pend = 8'h3F;
    ee = 1;
    @(negedge clk); @(negedge clk);
    check("R10 reset state", {27'd0, out_valid, out_code}, 32'd0);
    rst_n = 1'b1;
    // R10 latency: inputs driven at negedge appear after next rising edge
    pend = 8'h08; ee = 1;
    step_check("R10 latency R6");
    // R1 nothing pending
    pend = 8'h00;
    step_check("R1 none");
    check("R1 idle code", {28'd0, out_code}, 32'd0);

    // running sweep: R3 R4 R5 R6 R7
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 256; c++) begin
        pend = 8'(p); halted = 0;
        {ee, hv, pr, resume_rst, hv_capable, hdec_en, hv_ext_block, ext_guest_off} = 8'(c);
        step_check("R3 R4 R5 R6 R7 running sweep");
      end
    end
    // halted sweep: R2
    halted = 1; ee = 0; resume_rst = 0; hdec_en = 0; hv_capable = 0;
    for (int p = 0; p < 64; p++) begin
      for (int w = 0; w < 64; w++) begin
        pend = 8'(p); wake_en = 8'(w);
        step_check("R2 halted wake sweep");
      end
    end
    // R2 external wakes only with wake bit 2
    pend = 8'h04; wake_en = 8'h04;
    step_check("R2 ext wake");
    check("R2 ext code", {28'd0, out_code}, 32'd3);
    wake_en = 8'hFB;
    step_check("R2 ext no wake");
    check("R2 ext blocked", {31'd0, out_valid}, 32'd0);

    // R8 clear pulse
    halted = 0; wake_en = 0; ee = 1; hv = 0; hdec_en = 1; pend = 8'h02;
    step_check("R8 hdec select");
    check("R8 no ack no clear", {24'd0, clr_pend}, 32'd0);
    out_ready = 1; #1;
    check("R8 ack clears hdec", {24'd0, clr_pend}, 32'h02);
    pend = 8'h08;
    step_check("R8 dec select");
    check("R8 dec ack no clear", {24'd0, clr_pend}, 32'd0);
    pend = 8'h01;
    step_check("R3 mck select");
    check("R8 mck ack no clear", {24'd0, clr_pend}, 32'd0);
    out_ready = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule